// File: doc/BRIEF.md
# Lowest-Priority Logical Interrupt Router

This block takes interrupt messages from a single source and hands each one to one or more of up to eight processor-local interrupt controllers. Each processor slot has a one-hot logical ID: slot n answers to bit n of the message's 8-bit destination mask. The router works out which slots match, and then either delivers the message to every matching slot or picks a single matching slot, depending on the message's mode.

Each slot tracks a current priority. This is the larger of a task priority that software writes and the class (upper four vector bits) of the highest interrupt the slot is servicing. A slot that takes an interrupt stays at that priority until its acknowledge strobe arrives. In lowest-priority mode, later messages therefore move on to idle slots. Routing is decided combinationally from registered state, and the grant, vector and no-target flag are registered.

Top module: `irq_router`

## Requirements
- R1: After reset the grant, delivered vector and no-target flag are all zero, and every slot's task priority and in-service class are zero.
- R2: Slot n is a candidate exactly when bit n of `msg_dest` is set. A cleared bit (for example, bit 2 in 0xFB) excludes that slot.
- R3: With `msg_lowest`=1, the cycle after `msg_valid` the grant is one-hot on the candidate with the lowest current priority, and `grant_vector` equals `msg_vector`.
- R4: When candidates tie at the lowest current priority, the lowest-numbered slot is granted.
- R5: A slot's current priority is the larger of its task priority (written through `tpr_we`/`tpr_idx`/`tpr_data`) and its in-service class. An in-service class below the task priority does not raise it.
- R6: A granted slot's in-service class becomes the larger of its old class and `msg_vector[7:4]`. It holds until a one-cycle pulse on that slot's `ack` bit clears it to zero. If an acknowledge and a grant reach the same slot in the same cycle, the grant wins.
- R7: With `msg_lowest`=0 (fixed mode), the grant equals `msg_dest` ANDed with the present-slot mask, and every granted slot records the vector as in service.
- R8: When no slot matches, the grant and vector are zero and `no_target` is high for exactly the one cycle after `msg_valid`.
- R9: In a cycle after one without `msg_valid`, the grant is zero and `no_target` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Message strobe, one cycle per message |
| msg_dest | input | 8 | Logical destination mask |
| msg_vector | input | VEC_W | Interrupt vector |
| msg_lowest | input | 1 | 1 = lowest-priority delivery, 0 = fixed delivery |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_idx | input | 3 | Slot whose task priority is written |
| tpr_data | input | PRIO_W | Task priority value |
| ack | input | NPROC | Per-slot acknowledge strobes |
| grant | output | NPROC | Registered slot grant |
| grant_vector | output | VEC_W | Registered delivered vector, zero when nothing is granted |
| no_target | output | 1 | One-cycle flag for a message that matched no slot |

## Verification
The hardest situation to reach is a lowest-priority decision in which the lowest candidate is not the first one. Reaching it needs several slots held at different priorities at once. The stimulus builds this state step by step, using earlier grants that are never acknowledged, task-priority writes at uneven values, and a masked destination. Only then does it send the deciding message. It also sends a high-class vector to a slot whose task priority is set, so that both inputs to the priority maximum are exercised.

// File: rtl/lpr_pkg.sv
package lpr_pkg;
   localparam int MAX_SLOTS = 8;
   localparam int DEST_W    = 8;
   localparam int IDX_W     = 3;

   typedef enum logic {
      DLV_FIXED  = 1'b0,
      DLV_LOWEST = 1'b1
   } dlv_mode_e;
endpackage

// File: rtl/lpr_slot.sv
module lpr_slot #(
   parameter int PRIO_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tpr_we,
   input  logic [PRIO_W-1:0] tpr_data,
   input  logic              take,
   input  logic [PRIO_W-1:0] take_cls,
   input  logic              ack,
   output logic [PRIO_W-1:0] cur_prio
);
   logic [PRIO_W-1:0] tpr_q;
   logic [PRIO_W-1:0] isv_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tpr_q <= '0;
         isv_q <= '0;
      end else begin
         if (tpr_we)
            tpr_q <= tpr_data;
         if (take)
            isv_q <= (take_cls > isv_q) ? take_cls : isv_q;
         else if (ack)
            isv_q <= '0;
      end
   end

   assign cur_prio = (tpr_q > isv_q) ? tpr_q : isv_q;
endmodule

// File: rtl/lpr_pick.sv
module lpr_pick #(
   parameter int NPROC  = 8,
   parameter int PRIO_W = 4
) (
   input  logic [NPROC-1:0]             cand,
   input  logic [NPROC-1:0][PRIO_W-1:0] prio,
   input  logic                         lowest,
   output logic [NPROC-1:0]             sel,
   output logic                         none
);
   logic [NPROC-1:0]  one_hot;
   logic [PRIO_W-1:0] best;
   logic              found;

   always_comb begin
      one_hot = '0;
      best    = '1;
      found   = 1'b0;
      for (int i = 0; i < NPROC; i++) begin
         if (cand[i] && (!found || prio[i] < best)) begin
            found      = 1'b1;
            best       = prio[i];
            one_hot    = '0;
            one_hot[i] = 1'b1;
         end
      end
   end

   assign sel  = lowest ? one_hot : cand;
   assign none = ~|cand;
endmodule

// File: rtl/irq_router.sv
module irq_router
   import lpr_pkg::*;
#(
   parameter int NPROC  = 8,
   parameter int VEC_W  = 8,
   parameter int PRIO_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msg_valid,
   input  logic [7:0]        msg_dest,
   input  logic [VEC_W-1:0]  msg_vector,
   input  logic              msg_lowest,
   input  logic              tpr_we,
   input  logic [2:0]        tpr_idx,
   input  logic [PRIO_W-1:0] tpr_data,
   input  logic [NPROC-1:0]  ack,
   output logic [NPROC-1:0]  grant,
   output logic [VEC_W-1:0]  grant_vector,
   output logic              no_target
);
   localparam int CLS_LSB = VEC_W - PRIO_W;

   generate
      if (NPROC < 1 || NPROC > MAX_SLOTS) begin : g_bad_nproc
         $error("irq_router: NPROC must lie in 1..8");
      end
      if (VEC_W <= PRIO_W) begin : g_bad_vec
         $error("irq_router: VEC_W must exceed PRIO_W");
      end
   endgenerate

   logic [NPROC-1:0]             cand;
   logic [NPROC-1:0]             sel;
   logic                         none;
   logic [NPROC-1:0][PRIO_W-1:0] prio;
   logic [NPROC-1:0]             take;
   logic [PRIO_W-1:0]            cls;
   dlv_mode_e                    mode;

   assign mode = dlv_mode_e'(msg_lowest);
   assign cand = msg_dest[NPROC-1:0];
   assign cls  = msg_vector[VEC_W-1 -: PRIO_W];
   assign take = msg_valid ? sel : '0;

   generate
      if (NPROC < DEST_W) begin : g_unused_dest
         logic unused_hi;
         assign unused_hi = ^msg_dest[DEST_W-1:NPROC];
      end
      if (CLS_LSB > 0) begin : g_unused_vec
         logic unused_lo;
         assign unused_lo = ^msg_vector[CLS_LSB-1:0];
      end
   endgenerate

   generate
      for (genvar gi = 0; gi < NPROC; gi++) begin : g_slot
         logic wr_here;
         assign wr_here = tpr_we && (tpr_idx == IDX_W'(gi));
         lpr_slot #(.PRIO_W(PRIO_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .tpr_we   (wr_here),
            .tpr_data (tpr_data),
            .take     (take[gi]),
            .take_cls (cls),
            .ack      (ack[gi]),
            .cur_prio (prio[gi])
         );
      end
   endgenerate

   lpr_pick #(.NPROC(NPROC), .PRIO_W(PRIO_W)) u_pick (
      .cand   (cand),
      .prio   (prio),
      .lowest (mode == DLV_LOWEST),
      .sel    (sel),
      .none   (none)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant        <= '0;
         grant_vector <= '0;
         no_target    <= 1'b0;
      end else begin
         grant        <= take;
         grant_vector <= (msg_valid && !none) ? msg_vector : '0;
         no_target    <= msg_valid && none;
      end
   end
endmodule

// File: rtl/lpr_chk.sv
module lpr_chk #(
   parameter int NPROC  = 8,
   parameter int VEC_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             msg_valid,
   input logic [7:0]       msg_dest,
   input logic             msg_lowest,
   input logic [NPROC-1:0] grant,
   input logic [VEC_W-1:0] grant_vector,
   input logic             no_target
);
   logic [NPROC-1:0] dmask;
   assign dmask = msg_dest[NPROC-1:0];

   // R2
   grant_in_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |=> ((grant & ~$past(dmask)) == '0));

   // R3
   lowest_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_lowest && dmask != '0) |=> $onehot(grant));

   // R8
   no_target_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && dmask == '0) |=> (no_target && grant == '0 && grant_vector == '0));

   // R8
   no_target_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      no_target |=> (!no_target || $past(msg_valid)));

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !msg_valid |=> (grant == '0 && !no_target));
endmodule

bind irq_router lpr_chk #(.NPROC(NPROC), .VEC_W(VEC_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .msg_valid    (msg_valid),
   .msg_dest     (msg_dest),
   .msg_lowest   (msg_lowest),
   .grant        (grant),
   .grant_vector (grant_vector),
   .no_target    (no_target)
);

// File: tb/sim_irq_router.sv
module sim_irq_router;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       msg_valid = 1'b0;
   logic [7:0] msg_dest = '0;
   logic [7:0] msg_vector = '0;
   logic       msg_lowest = 1'b0;
   logic       tpr_we = 1'b0;
   logic [2:0] tpr_idx = '0;
   logic [3:0] tpr_data = '0;
   logic [NP-1:0] ack = '0;
   logic [NP-1:0] grant;
   logic [7:0] grant_vector;
   logic       no_target;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_router u0 (
      .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_dest(msg_dest),
      .msg_vector(msg_vector), .msg_lowest(msg_lowest), .tpr_we(tpr_we),
      .tpr_idx(tpr_idx), .tpr_data(tpr_data), .ack(ack), .grant(grant),
      .grant_vector(grant_vector), .no_target(no_target)
   );

   typedef struct {
      logic [NP-1:0] g;
      logic [7:0]    v;
      logic          nt;
      int            due;
      string         req;
   } exp_t;

   exp_t exp_q[$];
   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   logic [3:0] m_tpr [NP];
   logic [3:0] m_isv [NP];

   always @(posedge clk) cyc++;

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   always @(negedge clk) begin
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
         exp_t e;
         e = exp_q.pop_front();
         chk(grant == e.g, e.req, "grant", 32'(grant), 32'(e.g));
         chk(grant_vector == e.v, e.req, "vector", 32'(grant_vector), 32'(e.v));
         chk(no_target == e.nt, e.req, "no_target", 32'(no_target), 32'(e.nt));
      end
   end

   function automatic logic [3:0] cur(input int n);
      return (m_tpr[n] > m_isv[n]) ? m_tpr[n] : m_isv[n];
   endfunction

   task automatic send(input logic [7:0] d, input logic [7:0] v,
                       input logic low, input string req);
      exp_t e;
      logic [NP-1:0] g;
      int best;
      @(negedge clk);
      g = '0;
      best = -1;
      for (int n = 0; n < NP; n++) begin
         if (d[n]) begin
            if (!low) g[n] = 1'b1;
            else if (best < 0 || cur(n) < cur(best)) best = n;
         end
      end
      if (low && best >= 0) g[best] = 1'b1;
      for (int n = 0; n < NP; n++)
         if (g[n] && v[7:4] > m_isv[n]) m_isv[n] = v[7:4];
      e.g = g; e.v = (g != '0) ? v : 8'h00; e.nt = (d == 8'h00);
      e.due = cyc + 1; e.req = req;
      exp_q.push_back(e);
      msg_valid = 1'b1; msg_dest = d; msg_vector = v; msg_lowest = low;
      @(negedge clk);
      msg_valid = 1'b0;
   endtask

   task automatic idle_check(input string req);
      exp_t e;
      @(negedge clk);
      e.g = '0; e.v = 8'h00; e.nt = 1'b0; e.due = cyc + 1; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic do_ack(input int n);
      @(negedge clk);
      ack[n] = 1'b1;
      m_isv[n] = 4'h0;
      @(negedge clk);
      ack = '0;
   endtask

   task automatic set_tpr(input int n, input logic [3:0] p);
      @(negedge clk);
      tpr_we = 1'b1; tpr_idx = 3'(n); tpr_data = p;
      m_tpr[n] = p;
      @(negedge clk);
      tpr_we = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int n = 0; n < NP; n++) begin m_tpr[n] = 4'h0; m_isv[n] = 4'h0; end
      repeat (4) @(negedge clk);
      // R1 reset state at the ports
      chk(grant == '0, "R1", "grant", 32'(grant), 0);
      chk(grant_vector == '0, "R1", "vector", 32'(grant_vector), 0);
      chk(no_target == 1'b0, "R1", "no_target", 32'(no_target), 0);
      rst_n = 1'b1;
      // R1 R4: all idle after reset, broadcast ties go to slot 0
      send(8'hFF, 8'h31, 1'b1, "R1_R4");
      // R6: slot 0 busy at class 3, next goes to slot 1
      send(8'hFF, 8'h42, 1'b1, "R6");
      // R2: 0xFE removes slot 0, slot 1 busy, slot 2 chosen
      send(8'hFE, 8'h20, 1'b1, "R2");
      // R2: 0xFB removes slot 2, lowest idle is slot 3
      send(8'hFB, 8'h25, 1'b1, "R2_R3");
      // R6: acknowledge clears slot 0
      do_ack(0);
      send(8'h0F, 8'h55, 1'b1, "R6_ack");
      // R5: task priorities on the upper slots
      set_tpr(4, 4'h9);
      set_tpr(5, 4'h6);
      set_tpr(6, 4'h7);
      set_tpr(7, 4'h8);
      send(8'hF0, 8'h10, 1'b1, "R5");
      // R5: class 1 below task priority 6, slot 5 still lowest
      send(8'hF0, 8'h10, 1'b1, "R5_low_class");
      // R5: class A lifts slot 5 above its task priority
      send(8'h20, 8'hA0, 1'b1, "R5_high_class");
      send(8'hF0, 8'h11, 1'b1, "R3_after_raise");
      // R7: fixed mode multicast
      send(8'h0A, 8'h77, 1'b0, "R7");
      send(8'hFF, 8'h88, 1'b0, "R7_all");
      // R8: no slot matches
      send(8'h00, 8'h99, 1'b1, "R8");
      // R9: quiet cycle after no message
      idle_check("R9");
      idle_check("R8_pulse_end");
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R3", "pending", 32'(exp_q.size()), 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule